// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This unit tracks how trustworthy a CAN node still is on the bus. It keeps a transmit error counter and a receive error counter, and it turns them into one of three confinement states: error active, error passive or bus off. The protocol engine feeds it one-cycle event strobes. These mark a transmit fault, a receive fault, a clean transmit, a clean receive, and each run of 11 recessive bits seen on the bus.

The transmit counter is one bit wider than the receive counter. This lets it show a value above 255, which is the bus-off condition. From the counters the unit derives warning and passive flags for each direction, a combined warning flag and a bus-off flag. It also gives the error-frame type to use, a transmit-disable line, and an interrupt pulse. The interrupt fires when the node first enters a warning, passive or bus-off condition.

While the node is bus off, all counting events are ignored. The node comes back only after 128 runs of 11 recessive bits. At that point it returns to error active with both counters at zero.

Top module: `can_fault_confine`

## Requirements
- R1: After a synchronous reset, both counters are 0, `state_o` is 0 (error active), `flags_o` is 0, `irq_o` is 0, `active_frame_o` is 1 and `tx_disable_o` is 0.
- R2: Outside bus off, a `tx_err_i` strobe raises the transmit counter by 8. A `tx_ok_i` strobe lowers it by 1, but not below 0. When both strobes arrive in the same cycle, only the increase applies.
- R3: Outside bus off, an `rx_err_i` strobe raises the receive counter by 1, saturating at 255. An `rx_ok_i` strobe lowers it by 1, but not below 0. When both strobes arrive in the same cycle, only the increase applies.
- R4: A counter shows the effect of a strobe in the cycle after the strobe is sampled.
- R5: `state_o` is 1 (error passive) while the node is not bus off and at least one counter is 128 or more. `state_o` is 0 (error active) while both counters are below 128.
- R6: `state_o` is 2 (bus off) while the transmit counter is 256 or more. In that state, the four counting strobes have no effect on either counter.
- R7: While bus off, the 128th `rec11_i` strobe clears both counters and returns `state_o` to 0 in the next cycle. Any `rec11_i` strobe outside bus off has no effect, and the count of recessive runs restarts from 0 each time the node leaves bus off.
- R8: `flags_o` bit 0 is high while the transmit counter is at least 96. Bit 1 is high while the receive counter is at least 96. Bit 2 is high while either counter is at least 96.
- R9: `flags_o` bit 3 is high while the transmit counter is at least 128. Bit 4 is high while the receive counter is at least 128. Bit 5 is high while the transmit counter is at least 256.
- R10: `irq_o` is high for exactly the first cycle in which any of `flags_o` bits 0, 1, 3, 4 or 5 is newly set. A flag clearing, or bit 2 on its own, raises no interrupt.
- R11: `active_frame_o` is 1 only in error active, which selects active error frames. In error passive it is 0, which selects passive frames. `tx_disable_o` is 1 exactly in bus off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | Transmit fault strobe |
| rx_err_i | input | 1 | Receive fault strobe |
| tx_ok_i | input | 1 | Successful transmit strobe |
| rx_ok_i | input | 1 | Successful receive strobe |
| rec11_i | input | 1 | Strobe for each run of 11 recessive bits |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | 0 active, 1 passive, 2 bus off |
| flags_o | output | 6 | Status flags (bit layout in R8, R9) |
| irq_o | output | 1 | Error interrupt pulse on condition entry |
| active_frame_o | output | 1 | 1 selects active error frames |
| tx_disable_o | output | 1 | Blocks transmission while bus off |

## Verification
The bench drives several kinds of stimulus, and each separates a different failure:
- Long runs of single receive faults walk the receive counter through 96, 128 and the 255 ceiling. They then unwind it below zero, which separates correct saturation and floor handling from plain wraparound.
- Transmit faults that coincide with successful transmits show whether fault priority is honoured.
- Recessive-run strobes given outside bus off show that they are ignored.
- A climb into bus off, followed by counting strobes, shows that the counters are frozen. This is followed by 127 and then one more recessive-run strobe, which separates the exact recovery count from an off-by-one.
- A long weighted random mix, checked every clock, covers interrupt timing at each threshold crossing and repeated bus-off entries.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } fc_state_e;

    // bit 0 is tx_warn, bit 5 is bus_off
    typedef struct packed {
        logic bus_off;
        logic rx_pass;
        logic tx_pass;
        logic any_warn;
        logic rx_warn;
        logic tx_warn;
    } fc_flags_t;

    // flags that may raise the interrupt on entry (combined warning excluded)
    localparam fc_flags_t IRQ_MASK = '{bus_off: 1'b1, rx_pass: 1'b1, tx_pass: 1'b1,
                                       any_warn: 1'b0, rx_warn: 1'b1, tx_warn: 1'b1};

endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters #(
    parameter int TEC_W   = 9,
    parameter int REC_W   = 8,
    parameter int TX_STEP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             freeze,
    input  logic             clear,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec
);
    localparam logic [TEC_W-1:0] TMAX  = '1;
    localparam logic [REC_W-1:0] RMAX  = '1;
    localparam logic [TEC_W-1:0] STEP  = TEC_W'(TX_STEP);
    localparam logic [TEC_W-1:0] TSAFE = TMAX - STEP;

    logic [TEC_W-1:0] tec_nxt;
    logic [REC_W-1:0] rec_nxt;

    always_comb begin
        tec_nxt = tec;
        if (tx_err)
            tec_nxt = (tec > TSAFE) ? TMAX : tec + STEP;
        else if (tx_ok && tec != '0)
            tec_nxt = tec - 1'b1;
    end

    always_comb begin
        rec_nxt = rec;
        if (rx_err)
            rec_nxt = (rec == RMAX) ? RMAX : rec + 1'b1;
        else if (rx_ok && rec != '0)
            rec_nxt = rec - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tec <= '0;
            rec <= '0;
        end else if (!freeze) begin
            tec <= tec_nxt;
            rec <= rec_nxt;
        end
    end

    p_tx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_err && !freeze && !clear && tec <= TSAFE) |=> (tec == $past(tec) + STEP));

    p_rec_sat_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_err && !freeze && !clear && rec == RMAX) |=> (rec == RMAX));

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clear) |=> ($stable(tec) && $stable(rec)));

endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
    parameter int TEC_W     = 9,
    parameter int BOFF_LIM  = 256,
    parameter int RECOV_SEQ = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TEC_W-1:0] tec,
    input  logic             rec11,
    output logic             boff,
    output logic             recover
);
    localparam int RC_W = $clog2(RECOV_SEQ + 1);
    localparam logic [TEC_W-1:0] BOFF_V = TEC_W'(BOFF_LIM);
    localparam logic [RC_W-1:0]  LAST   = RC_W'(RECOV_SEQ - 1);

    logic [RC_W-1:0] runs;

    assign boff    = (tec >= BOFF_V);
    assign recover = boff && rec11 && (runs == LAST);

    always_ff @(posedge clk) begin
        if (rst || !boff || recover)
            runs <= '0;
        else if (rec11)
            runs <= runs + 1'b1;
    end

    p_recov_clear_r7: assert property (@(posedge clk) disable iff (rst)
        recover |=> (tec == '0));

    p_runs_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !boff |=> (runs == '0));

endmodule

// File: rtl/can_fc_status.sv
module can_fc_status
    import can_fc_pkg::*;
#(
    parameter int TEC_W    = 9,
    parameter int REC_W    = 8,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    input  logic             boff,
    output fc_state_e        state,
    output fc_flags_t        flags,
    output logic             irq,
    output logic             active_frame,
    output logic             tx_disable
);
    localparam logic [TEC_W-1:0] TWARN = TEC_W'(WARN_LIM);
    localparam logic [TEC_W-1:0] TPASS = TEC_W'(PASS_LIM);
    localparam logic [REC_W-1:0] RWARN = REC_W'(WARN_LIM);
    localparam logic [REC_W-1:0] RPASS = REC_W'(PASS_LIM);

    fc_flags_t flags_q;

    always_comb begin
        flags.tx_warn  = (tec >= TWARN);
        flags.rx_warn  = (rec >= RWARN);
        flags.any_warn = flags.tx_warn || flags.rx_warn;
        flags.tx_pass  = (tec >= TPASS);
        flags.rx_pass  = (rec >= RPASS);
        flags.bus_off  = boff;
    end

    always_comb begin
        if (boff)
            state = ST_BUSOFF;
        else if (flags.tx_pass || flags.rx_pass)
            state = ST_PASSIVE;
        else
            state = ST_ACTIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags;
    end

    assign irq          = |(flags & ~flags_q & IRQ_MASK);
    assign active_frame = (state == ST_ACTIVE);
    assign tx_disable   = (state == ST_BUSOFF);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    p_pass_implies_warn_r8: assert property (@(posedge clk) disable iff (rst)
        flags.tx_pass |-> flags.tx_warn);

    p_frame_sel_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_disable, active_frame}));

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int TEC_W     = 9,
    parameter int REC_W     = 8,
    parameter int TX_STEP   = 8,
    parameter int WARN_LIM  = 96,
    parameter int PASS_LIM  = 128,
    parameter int BOFF_LIM  = 256,
    parameter int RECOV_SEQ = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             rec11_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o,
    output logic [1:0]       state_o,
    output logic [5:0]       flags_o,
    output logic             irq_o,
    output logic             active_frame_o,
    output logic             tx_disable_o
);
    logic      boff;
    logic      recover;
    fc_state_e state;
    fc_flags_t flags;

    can_fc_counters #(.TEC_W(TEC_W), .REC_W(REC_W), .TX_STEP(TX_STEP)) u_cnt (
        .clk(clk), .rst(rst),
        .tx_err(tx_err_i), .rx_err(rx_err_i), .tx_ok(tx_ok_i), .rx_ok(rx_ok_i),
        .freeze(boff), .clear(recover),
        .tec(tec_o), .rec(rec_o)
    );

    can_fc_recovery #(.TEC_W(TEC_W), .BOFF_LIM(BOFF_LIM), .RECOV_SEQ(RECOV_SEQ)) u_rcv (
        .clk(clk), .rst(rst), .tec(tec_o), .rec11(rec11_i),
        .boff(boff), .recover(recover)
    );

    can_fc_status #(.TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
                    .PASS_LIM(PASS_LIM)) u_sts (
        .clk(clk), .rst(rst), .tec(tec_o), .rec(rec_o), .boff(boff),
        .state(state), .flags(flags), .irq(irq_o),
        .active_frame(active_frame_o), .tx_disable(tx_disable_o)
    );

    assign state_o = state;
    assign flags_o = flags;

endmodule

// File: tb/tb_can_fault_confine.sv
`timescale 1ns/1ps
module tb_can_fault_confine;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, rec11 = 0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] state;
    logic [5:0] flags;
    logic irq, act, txdis;

    int checks = 0;
    int fails  = 0;
    bit armed  = 0;
    bit done   = 0;

    int m_tec = 0, m_rec = 0, m_rc = 0, m_fq = 0;

    always #2.5 clk = ~clk;

    can_fault_confine dut (
        .clk(clk), .rst(rst),
        .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
        .rec11_i(rec11),
        .tec_o(tec), .rec_o(rec), .state_o(state), .flags_o(flags),
        .irq_o(irq), .active_frame_o(act), .tx_disable_o(txdis)
    );

    function automatic int mflags(int t, int r);
        int f;
        f = 0;
        if (t >= 96)  f |= 1;
        if (r >= 96)  f |= 2;
        if (t >= 96 || r >= 96) f |= 4;
        if (t >= 128) f |= 8;
        if (r >= 128) f |= 16;
        if (t >= 256) f |= 32;
        return f;
    endfunction

    function automatic int mstate(int t, int r);
        if (t >= 256) return 2;
        if (t >= 128 || r >= 128) return 1;
        return 0;
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_tec = 0; m_rec = 0; m_rc = 0; m_fq = 0;
        end else begin
            m_fq = mflags(m_tec, m_rec);
            if (m_tec >= 256) begin
                if (rec11) begin
                    m_rc++;
                    if (m_rc == 128) begin
                        m_tec = 0; m_rec = 0; m_rc = 0;
                    end
                end
            end else begin
                m_rc = 0;
                if (tx_err)                  m_tec = m_tec + 8;
                else if (tx_ok && m_tec > 0) m_tec = m_tec - 1;
                if (rx_err)                  m_rec = (m_rec == 255) ? 255 : m_rec + 1;
                else if (rx_ok && m_rec > 0) m_rec = m_rec - 1;
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            int ef, es;
            ef = mflags(m_tec, m_rec);
            es = mstate(m_tec, m_rec);
            chk("R2 R4 R6 R7 tec", int'(tec), m_tec);
            chk("R3 R4 R6 R7 rec", int'(rec), m_rec);
            chk("R5 R6 state", int'(state), es);
            chk("R8 R9 flags", int'(flags), ef);
            chk("R10 irq", int'(irq), ((ef & ~m_fq & 6'b111011) != 0) ? 1 : 0);
            chk("R11 active_frame", int'(act), (es == 0) ? 1 : 0);
            chk("R11 tx_disable", int'(txdis), (es == 2) ? 1 : 0);
        end
    end

    task automatic ev(bit te, bit re, bit to, bit ro, bit r11);
        @(negedge clk);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; rec11 = r11;
    endtask

    task automatic idle(int n);
        repeat (n) ev(0, 0, 0, 0, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 tec", int'(tec), 0);
        chk("R1 rec", int'(rec), 0);
        chk("R1 state", int'(state), 0);
        chk("R1 flags", int'(flags), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 active_frame", int'(act), 1);
        chk("R1 tx_disable", int'(txdis), 0);
        rst = 1'b0;
        armed = 1;

        // R3: receive ramp through 96 and 128 into saturation, then floor
        repeat (260) ev(0, 1, 0, 0, 0);
        repeat (260) ev(0, 0, 0, 1, 0);
        repeat (5)   ev(0, 1, 0, 1, 0);
        repeat (10)  ev(0, 0, 0, 1, 0);

        // R7: recessive runs outside bus off are ignored
        repeat (5) ev(0, 0, 0, 0, 1);
        idle(2);

        // R2: transmit steps, priority, decrement to floor
        repeat (12) ev(1, 0, 0, 0, 0);
        repeat (3)  ev(0, 0, 1, 0, 0);
        repeat (4)  ev(1, 0, 1, 0, 0);
        repeat (200) ev(0, 0, 1, 0, 0);

        // R6: climb into bus off, then try to disturb counters
        repeat (32) ev(1, 0, 0, 0, 0);
        ev(1, 0, 0, 0, 0);
        ev(0, 1, 0, 0, 0);
        ev(0, 0, 1, 0, 0);
        ev(0, 0, 0, 1, 0);
        ev(1, 1, 1, 1, 0);
        idle(2);

        // R7: 127 runs keep bus off, the 128th recovers
        for (int i = 0; i < 127; i++) begin
            ev(0, 0, 0, 0, 1);
            if (i % 16 == 0) idle(1);
        end
        idle(3);
        ev(0, 0, 0, 0, 1);
        idle(3);

        // weighted random mix across all thresholds and repeated bus off
        for (int i = 0; i < 4000; i++) begin
            int u;
            u = $urandom;
            ev((u[2:0] == 3'd0), (u[5:3] < 3'd3), (u[8:6] < 3'd2),
               (u[11:9] < 3'd2), (u[13:12] != 2'd0));
        end
        idle(4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule